// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block sits between a clocked host and an asynchronous pseudo-static RAM of 256K bytes. The host hands over one word at a time through a valid/ready request port that carries an address, write data and a write flag. The controller then drives the memory's active-low chip enable, output enable and write enable strobes. Every strobe comes from a flip-flop and is held for a whole number of clocks, chosen so that each minimum time of the memory is met. The data bus is split into an output word, an input word and a drive enable, so that a tri-state pad can be placed outside the block.

All minimum times are computed when the design is elaborated, using ceiling division of nanosecond limits by the clock period. A grade parameter picks between the faster and the slower timing set. The memory refreshes itself internally, and that refresh can be starved if accesses never leave it a pause. To prevent this, a guard counter measures how long chip enable has stayed busy without a high period of at least one read cycle. Before a 15 µs window runs out, the controller withholds ready and inserts such a high period.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and right after it, chip enable, output enable and write enable are high, the data drive enable is low, read-data valid is low and ready is high.
- R2: During a read, chip enable and output enable are low, write enable is high and the data drive enable is low.
- R3: A write first spends one clock with chip enable low, write enable high and the bus driven. It then pulls write enable low. Output enable stays high for the whole write.
- R4: The data drive enable is only ever high while chip enable is low and output enable is high.
- R5: Read data is sampled only after both the address access time and the output-enable access time have passed. Read-data valid rises exactly 12 clock falls after the accepting edge in the default setting (one more than ceil(55/5)), and it stays high for exactly one cycle.
- R6: Write enable stays low for at least the write pulse minimum. Write data and address hold steady from before the pulse until write enable rises, for at least the data setup minimum.
- R7: Two consecutive falling edges of chip enable are at least one read cycle time apart.
- R8: Ready is high only while the controller is idle with chip enable high. A request is taken on a clock edge where valid and ready are both high, and ready is low during the clock that follows.
- R9: Chip enable never stays busy for longer than 15 µs without a high period of at least one read cycle time. When the guard forces such a period, ready stays low for all of it, even if a request is waiting.
- R10: A read returns the byte most recently written to the same address, including the lowest and the highest of the 18-bit addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| rd_data | output | 8 | Byte read from memory |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Data returned from memory pads |

## Verification
In the default setting (5 ns clock, fast grade), a read's valid pulse is due on the 12th clock fall after the accepting edge. Read strobes show at the first fall and the write pulse at the second. After a write, ready returns two falls after chip enable rises. The bench acts on the clock edge and then counts clock falls one by one, comparing each port at the exact fall where its value is due. A behavioural memory model samples the strobes on every falling edge. It checks each minimum as a count of clocks times the period, and it holds back valid read data until both access times have passed. A read sampled too early therefore returns corrupted data.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    IDLE,
    READ_ACCESS,
    READ_DONE,
    WRITE_SETUP,
    WRITE_PULSE,
    WRITE_RECOVER,
    REFRESH_GAP
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // nanosecond minimums per speed grade
  function automatic int unsigned cycle_ns(bit fast);
    return fast ? 55 : 70;
  endfunction

  function automatic int unsigned addr_access_ns(bit fast);
    return fast ? 55 : 70;
  endfunction

  function automatic int unsigned oe_access_ns(bit fast);
    return fast ? 25 : 35;
  endfunction

  function automatic int unsigned we_pulse_ns(bit fast);
    return fast ? 40 : 45;
  endfunction

  function automatic int unsigned data_setup_ns(bit fast);
    return fast ? 25 : 25;
  endfunction

  // pin levels wanted in each state
  function automatic strobe_t strobes_for(ctrl_state_e s);
    strobe_t r;
    case (s)
      READ_ACCESS: r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      WRITE_SETUP: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      WRITE_PULSE: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      default:     r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] target,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = (cnt_q == target - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/psram_refresh_guard.sv
module psram_refresh_guard #(
  parameter int unsigned GAP_CLK   = 11,
  parameter int unsigned LIMIT_CLK = 2970
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic refresh_due
);
  localparam int unsigned GW = $clog2(GAP_CLK + 1);
  localparam int unsigned LW = $clog2(LIMIT_CLK + 1);

  logic [GW-1:0] hi_run_q;
  logic [LW-1:0] busy_q;
  logic          gap_met;

  assign gap_met     = ce_n && (hi_run_q == GW'(GAP_CLK - 1));
  assign refresh_due = (busy_q == LW'(LIMIT_CLK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      busy_q   <= '0;
    end else begin
      if (!ce_n)        hi_run_q <= '0;
      else if (!gap_met) hi_run_q <= hi_run_q + GW'(1);
      if (gap_met)           busy_q <= '0;
      else if (!refresh_due) busy_q <= busy_q + LW'(1);
    end
  end
endmodule

// File: rtl/psram_pin_drive.sv
module psram_pin_drive
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_e       next_state,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  strobe_t strobe_q;

  assign mem_ce_n  = strobe_q.ce_n;
  assign mem_oe_n  = strobe_q.oe_n;
  assign mem_we_n  = strobe_q.we_n;
  assign mem_dq_oe = strobe_q.dq_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q   <= strobes_for(IDLE);
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      strobe_q <= strobes_for(next_state);
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rd_data <= mem_dq_in;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 5,
  parameter bit          FAST_GRADE      = 1'b1,
  parameter int unsigned GUARD_WINDOW_NS = 15000,
  parameter int unsigned ADDR_W          = 18,
  parameter int unsigned DATA_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RC_CLK  = ns_to_clk(cycle_ns(FAST_GRADE), CLK_PERIOD_NS);
  localparam int unsigned ACC_CLK = max_u(ns_to_clk(addr_access_ns(FAST_GRADE), CLK_PERIOD_NS),
                                          ns_to_clk(oe_access_ns(FAST_GRADE), CLK_PERIOD_NS));
  localparam int unsigned RD_HOLD = max_u(RC_CLK, ACC_CLK);
  localparam int unsigned WP_CLK  = max_u(max_u(ns_to_clk(we_pulse_ns(FAST_GRADE), CLK_PERIOD_NS),
                                                ns_to_clk(data_setup_ns(FAST_GRADE), CLK_PERIOD_NS)),
                                          RC_CLK - 1);
  localparam int unsigned SPAN    = max_u(RD_HOLD, WP_CLK + 1) + 2;
  localparam int unsigned WIN_CLK = ns_to_clk(GUARD_WINDOW_NS, CLK_PERIOD_NS);
  localparam int unsigned LIMIT   = WIN_CLK - 2 * SPAN - 4;
  localparam int unsigned TW      = $clog2(max_u(RD_HOLD, WP_CLK) + 1);

  ctrl_state_e   state_q, state_d;
  logic          phase_done;
  logic [TW-1:0] phase_len;
  logic          accept;
  logic          capture_evt;
  logic          refresh_due;

  assign req_ready   = (state_q == IDLE) && !refresh_due;
  assign accept      = req_valid && req_ready;
  assign capture_evt = (state_q == READ_ACCESS) && phase_done;
  assign rd_valid    = (state_q == READ_DONE);

  always_comb begin
    case (state_q)
      READ_ACCESS: phase_len = TW'(RD_HOLD);
      WRITE_PULSE: phase_len = TW'(WP_CLK);
      REFRESH_GAP: phase_len = TW'(RC_CLK);
      default:     phase_len = TW'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      IDLE: begin
        if (refresh_due)  state_d = REFRESH_GAP;
        else if (accept)  state_d = req_write ? WRITE_SETUP : READ_ACCESS;
      end
      READ_ACCESS:   if (phase_done) state_d = READ_DONE;
      READ_DONE:     state_d = IDLE;
      WRITE_SETUP:   state_d = WRITE_PULSE;
      WRITE_PULSE:   if (phase_done) state_d = WRITE_RECOVER;
      WRITE_RECOVER: state_d = IDLE;
      REFRESH_GAP:   if (phase_done) state_d = IDLE;
      default:       state_d = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= IDLE;
    else        state_q <= state_d;
  end

  psram_phase_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .target  (phase_len),
    .done    (phase_done)
  );

  psram_refresh_guard #(.GAP_CLK(RC_CLK), .LIMIT_CLK(LIMIT)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (mem_ce_n),
    .refresh_due (refresh_due)
  );

  psram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_state (state_d),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture_evt),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 5,
  parameter bit          FAST_GRADE      = 1'b1,
  parameter int unsigned GUARD_WINDOW_NS = 15000,
  parameter int unsigned ADDR_W          = 18,
  parameter int unsigned DATA_W          = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              capture_evt,
  input logic              refresh_due
);
  localparam int unsigned RC_MIN  = ns_to_clk(cycle_ns(FAST_GRADE), CLK_PERIOD_NS);
  localparam int unsigned ACC_MIN = max_u(ns_to_clk(addr_access_ns(FAST_GRADE), CLK_PERIOD_NS),
                                          ns_to_clk(oe_access_ns(FAST_GRADE), CLK_PERIOD_NS));
  localparam int unsigned WP_MIN  = ns_to_clk(we_pulse_ns(FAST_GRADE), CLK_PERIOD_NS);
  localparam int unsigned WIN_CLK = GUARD_WINDOW_NS / CLK_PERIOD_NS;

  logic [15:0] we_run, rd_run, since_fall, hi_run, act_run;
  logic        ce_prev;
  logic        fall_now;

  assign fall_now = ce_prev && !mem_ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run     <= '0;
      rd_run     <= '0;
      since_fall <= 16'hFFFF;
      hi_run     <= '0;
      act_run    <= '0;
      ce_prev    <= 1'b1;
    end else begin
      ce_prev <= mem_ce_n;
      we_run  <= !mem_we_n ? we_run + 16'd1 : 16'd0;
      rd_run  <= (!mem_ce_n && !mem_oe_n) ? rd_run + 16'd1 : 16'd0;
      if (fall_now)                  since_fall <= 16'd1;
      else if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
      hi_run <= mem_ce_n ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
      if (mem_ce_n && (hi_run + 16'd1 >= 16'(RC_MIN))) act_run <= '0;
      else if (act_run != 16'hFFFF)                   act_run <= act_run + 16'd1;
    end
  end

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_dq_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  p_sample_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (rd_run + 16'd1 >= 16'(ACC_MIN)));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= 16'(WP_MIN)));

  p_wdata_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

  p_cycle_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_now |-> (since_fall >= 16'(RC_MIN)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  p_guard_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_run <= 16'(WIN_CLK));

  p_guard_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_due |-> !req_ready);
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .CLK_PERIOD_NS   (CLK_PERIOD_NS),
  .FAST_GRADE      (FAST_GRADE),
  .GUARD_WINDOW_NS (GUARD_WINDOW_NS),
  .ADDR_W          (ADDR_W),
  .DATA_W          (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dq_out  (mem_dq_out),
  .mem_dq_oe   (mem_dq_oe),
  .capture_evt (capture_evt),
  .refresh_due (refresh_due)
);

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;
  localparam int T_NS    = 5;
  localparam int TRC_NS  = 55;
  localparam int TAA_NS  = 55;
  localparam int TOE_NS  = 25;
  localparam int TPWE_NS = 40;
  localparam int TSD_NS  = 25;
  localparam int WIN_NS  = 15000;
  localparam int RC_B    = (TRC_NS + T_NS - 1) / T_NS;
  localparam int RD_LAT  = (TAA_NS + T_NS - 1) / T_NS + 1;
  localparam int WIN_B   = WIN_NS / T_NS;

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 18'h00000, 8'h3C},
    '{1'b1, 18'h3FFFF, 8'hC3},
    '{1'b1, 18'h00001, 8'h5A},
    '{1'b0, 18'h00000, 8'h3C},
    '{1'b0, 18'h3FFFF, 8'hC3},
    '{1'b0, 18'h00001, 8'h5A},
    '{1'b1, 18'h00000, 8'hFF},
    '{1'b0, 18'h00000, 8'hFF},
    '{1'b1, 18'h20000, 8'h00},
    '{1'b0, 18'h20000, 8'h00},
    '{1'b0, 18'h3FFFF, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  psram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // behavioural memory and timing monitor
  bit [7:0]    pmem [int];
  int          rd_n = 0, we_cnt = 0, stab = 0, stab_w = 0;
  int          since_fall = 1000, hi_run = 0, act_run = 0, act_max = 0;
  int          gaprun = 0, gap_seen = 0;
  bit          prev_we = 1'b1, prev_ce = 1'b1;
  logic [7:0]  last_dq = '0, wd = '0;
  logic [17:0] wa = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && (mem_ce_n || !mem_oe_n))
        check(1'b0, "R4 bus driven while released", {mem_ce_n, mem_oe_n}, 2'b01);
      if (!mem_we_n && !mem_oe_n)
        check(1'b0, "R3 output enable low in write", mem_oe_n, 1);
      // read data path
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        rd_n++;
        if (rd_n * T_NS >= TAA_NS && rd_n * T_NS >= TOE_NS)
          mem_dq_in <= pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 8'h00;
        else
          mem_dq_in <= 8'hE7;
      end else begin
        rd_n = 0;
        mem_dq_in <= 8'hE7;
      end
      // write path
      if (mem_dq_oe && mem_dq_out == last_dq && stab > 0) stab++;
      else if (mem_dq_oe) stab = 1;
      else stab = 0;
      last_dq = mem_dq_out;
      if (!mem_we_n) begin
        we_cnt++;
        wa = mem_addr;
        wd = mem_dq_out;
        stab_w = stab;
      end
      if (mem_we_n && !prev_we) begin
        check(we_cnt * T_NS >= TPWE_NS, "R6 write pulse width", we_cnt * T_NS, TPWE_NS);
        check(stab_w * T_NS >= TSD_NS, "R6 data setup", stab_w * T_NS, TSD_NS);
        pmem[int'(wa)] = wd;
        we_cnt = 0;
      end
      // cycle time
      if (!mem_ce_n && prev_ce) begin
        check(since_fall >= RC_B, "R7 chip enable cycle", since_fall, RC_B);
        since_fall = 1;
      end else if (since_fall < 1000) since_fall++;
      // refresh guard
      if (mem_ce_n) hi_run++;
      else hi_run = 0;
      if (hi_run >= RC_B) act_run = 0;
      else act_run++;
      if (act_run > act_max) act_max = act_run;
      if (req_valid && !req_ready && mem_ce_n) gaprun++;
      else gaprun = 0;
      if (gaprun == RC_B) gap_seen++;
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "watchdog expired", cyc, 100000);
      finish_run();
    end
  end

  task automatic do_access(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int lat;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
    if (wr) begin
      check(!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe, "R3 write setup strobes",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
      @(negedge clk);
      check(!mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == d && mem_addr == a,
            "R3 write pulse strobes and data", {mem_we_n, mem_dq_out}, {1'b0, d});
      while (!req_ready) @(negedge clk);
    end else begin
      check(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == a,
            "R2 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
      lat = 1;
      while (!rd_valid && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      check(lat == RD_LAT, "R5 read valid latency", lat, RD_LAT);
      check(rd_data == d, "R10 read data", rd_data, d);
      @(negedge clk);
      check(!rd_valid, "R5 valid lasts one cycle", rd_valid, 0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
          "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
          "R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready},
          6'b111001);

    // vector table walk (R2 R3 R5 R6 R8 R10)
    for (int i = 0; i < NV; i++) begin
      do_access(VECS[i].wr, VECS[i].addr, VECS[i].data);
      repeat (i % 3) @(negedge clk);
    end

    // R9: host keeps reads coming back to back for longer than the window
    req_write = 1'b0;
    req_addr  = 18'h00000;
    req_valid = 1'b1;
    for (int k = 0; k < WIN_B + 400; k++) begin
      @(negedge clk);
      if (rd_valid) check(rd_data == 8'hFF, "R10 data during sustained reads", rd_data, 8'hFF);
    end
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(gap_seen >= 1, "R9 forced chip enable gap with ready low", gap_seen, 1);
    check(act_max <= WIN_B, "R9 busy run bounded by window", act_max, WIN_B);

    // R8: ready returns once idle
    check(req_ready && mem_ce_n, "R8 ready when idle", {req_ready, mem_ce_n}, 2'b11);
    finish_run();
  end
endmodule